// File: doc/BRIEF.md
# Dual-Mode FM0 / Manchester Line Encoder

This block turns a serial bit stream into a DC-balanced two-level line waveform for a short-range vehicle and roadside radio link. Every data bit occupies two clock cycles of a single clock that runs at twice the bit rate. The first cycle carries the bit's first-half level and the second cycle carries its second-half level. A mode input selects either FM0 coding or Manchester coding for each bit.

FM0 needs only one stored level: the most recent second-half level driven on the line. The next first-half level is its inverse. The next second-half level is that stored level XORed with the data bit. The same register is also loaded with the line's second-half level while Manchester coding is selected. Because of this, a return to FM0 always starts with a level change at the bit boundary. The line output comes from a register, so it is free of glitches. It lags the accepted bit by one half-bit.

The input side works as a valid/ready stream that cannot be stalled. The line must never pause, so `in_ready` is high for exactly one cycle in every two: the first cycle of each bit period. A bit is taken only in a cycle where `in_ready` is high. If `in_valid` is low in that cycle, the block codes a filler bit of 0 instead. Data, valid and mode presented while `in_ready` is low are ignored.

Top module: `line_encoder_dual`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `line_out` is 1, `line_first` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 in the first cycle after reset and then alternates every cycle. Inputs are sampled only in cycles where `in_ready` is 1.
- R3: In FM0 mode (`in_mode`=0), a bit of 0 gives a second-half level that differs from its first-half level.
- R4: In FM0 mode, a bit of 1 gives a second-half level equal to its first-half level.
- R5: In FM0 mode, the first-half level of every bit differs from the line level in the cycle just before it. This includes the first bit after reset, which starts at 0.
- R6: In Manchester mode (`in_mode`=1), the first-half level equals the data bit and the second-half level is its inverse.
- R7: The mode is sampled together with the data. A change of `in_mode` while `in_ready` is 0 does not affect the bit being driven.
- R8: The first-half level of an accepted bit appears on `line_out` in the cycle after acceptance and stays for two cycles in total. `line_first` is 1 exactly in that first-half cycle.
- R9: The FM0 state follows the line's second-half level in Manchester mode too. The first FM0 bit after a Manchester bit therefore starts with the inverse of the preceding second-half level.
- R10: If `in_valid` is 0 in a cycle where `in_ready` is 1, a bit of 0 is coded in the selected mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data bit present |
| in_data | input | 1 | Serial data bit |
| in_mode | input | 1 | 0 = FM0, 1 = Manchester |
| in_ready | output | 1 | High in the cycle in which a bit is taken |
| line_out | output | 1 | Registered encoded line level |
| line_first | output | 1 | High while `line_out` carries a first-half level |

## Verification
The hardest case to reach is the return from Manchester to FM0. The boundary rule then depends on the state register having followed the Manchester second-half levels, and a path that forgot them would fail only on some bit patterns. The stimulus drives long stretches that pick a random mode for each bit, and it also toggles `in_mode` and `in_valid` in the cycles where they must be ignored. Runs of missing data are mixed into both modes, so that the filler bit also crosses mode changes.

// File: rtl/enc_pkg.sv
package enc_pkg;
  typedef enum logic {
    MODE_FM0   = 1'b0,
    MODE_MANCH = 1'b1
  } line_mode_e;
endpackage

// File: rtl/enc_phase.sv
module enc_phase (
  input  logic clk,
  input  logic rst,
  output logic bit_start
);
  logic half_q;

  always_ff @(posedge clk) begin
    if (rst) half_q <= 1'b0;
    else     half_q <= ~half_q;
  end

  assign bit_start = ~half_q;
endmodule

// File: rtl/enc_fm0_state.sv
module enc_fm0_state #(
  parameter logic INIT_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic bit_in,
  input  logic next_level,
  output logic lvl_a,
  output logic lvl_b
);
  logic last_q;

  // first half always opposes the last driven level; second half keeps or flips
  assign lvl_a = ~last_q;
  assign lvl_b = bit_in ^ last_q;

  always_ff @(posedge clk) begin
    if (rst)       last_q <= INIT_LEVEL;
    else if (step) last_q <= next_level;
  end
endmodule

// File: rtl/enc_manch.sv
module enc_manch (
  input  logic bit_in,
  output logic lvl_a,
  output logic lvl_b
);
  assign lvl_a = bit_in;
  assign lvl_b = ~bit_in;
endmodule

// File: rtl/line_encoder_dual.sv
module line_encoder_dual
  import enc_pkg::*;
#(
  parameter logic INIT_LEVEL = 1'b1,
  parameter logic IDLE_BIT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_data,
  input  logic in_mode,
  output logic in_ready,
  output logic line_out,
  output logic line_first
);
  logic       bit_start;
  logic       bit_eff;
  logic       fm0_a, fm0_b, man_a, man_b;
  logic       sel_a, sel_b;
  line_mode_e mode_in;
  line_mode_e mode_q;
  logic       bit_q, second_q, line_q, first_q;

  enc_phase u_phase (.clk(clk), .rst(rst), .bit_start(bit_start));

  assign bit_eff = in_valid ? in_data : IDLE_BIT;
  assign mode_in = line_mode_e'(in_mode);

  enc_manch u_manch (.bit_in(bit_eff), .lvl_a(man_a), .lvl_b(man_b));

  assign sel_a = (mode_in == MODE_MANCH) ? man_a : fm0_a;
  assign sel_b = (mode_in == MODE_MANCH) ? man_b : fm0_b;

  enc_fm0_state #(.INIT_LEVEL(INIT_LEVEL)) u_fm0 (
    .clk(clk), .rst(rst), .step(bit_start), .bit_in(bit_eff),
    .next_level(sel_b), .lvl_a(fm0_a), .lvl_b(fm0_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q   <= INIT_LEVEL;
      second_q <= INIT_LEVEL;
      first_q  <= 1'b0;
      bit_q    <= 1'b0;
      mode_q   <= MODE_FM0;
    end else if (bit_start) begin
      line_q   <= sel_a;
      second_q <= sel_b;
      first_q  <= 1'b1;
      bit_q    <= bit_eff;
      mode_q   <= mode_in;
    end else begin
      line_q   <= second_q;
      first_q  <= 1'b0;
    end
  end

  assign in_ready   = bit_start;
  assign line_out   = line_q;
  assign line_first = first_q;

  p_first_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
    first_q |-> !bit_start);

  p_fm0_boundary_r5: assert property (@(posedge clk) disable iff (rst)
    (first_q && mode_q == MODE_FM0) |-> (line_q != $past(line_q)));

  p_fm0_zero_mid_r3: assert property (@(posedge clk) disable iff (rst)
    (!first_q && $past(first_q) && mode_q == MODE_FM0 && !bit_q) |-> (line_q != $past(line_q)));

  p_fm0_one_mid_r4: assert property (@(posedge clk) disable iff (rst)
    (!first_q && $past(first_q) && mode_q == MODE_FM0 && bit_q) |-> (line_q == $past(line_q)));

  p_manch_mid_r6: assert property (@(posedge clk) disable iff (rst)
    (!first_q && $past(first_q) && mode_q == MODE_MANCH) |-> (line_q == !bit_q && $past(line_q) == bit_q));

  p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !first_q |-> $stable(mode_q));
endmodule

// File: tb/test_line_encoder_dual.sv
`timescale 1ns/1ps
module test_line_encoder_dual;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_data = 1'b0, in_mode = 1'b0;
  logic in_ready, line_out, line_first;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  line_encoder_dual i_line_encoder_dual (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_mode(in_mode), .in_ready(in_ready), .line_out(line_out),
    .line_first(line_first)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference state
  logic  e_ready, e_line, e_first, last2, pend, m_l, prev_line, bitv;
  string tag_line, tag_mid;

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", line_out, 1'b1);
    chk("R1", line_first, 1'b0);
    rst = 1'b0;
    #0.1;
    chk("R1", in_ready, 1'b1);
    e_ready = 1'b1; e_line = 1'b1; e_first = 1'b0;
    last2 = 1'b1; pend = 1'b1; m_l = 1'b0; prev_line = 1'b1;
    tag_mid = "R3";
    for (int c = 0; c < 1600; c++) begin
      int seg;
      seg = c / 400;
      // drive
      if (e_ready) begin
        in_data  = 1'($urandom % 2);
        in_valid = (seg == 3) ? ($urandom % 3 != 0) : 1'b1;
        in_mode  = (seg == 0) ? 1'b0 : (seg == 1) ? 1'b1 : 1'($urandom % 2);
      end else begin
        in_data  = 1'($urandom % 2);
        in_valid = 1'($urandom % 2);
        if (seg >= 2) in_mode = 1'($urandom % 2);
      end
      // reference model for the next cycle
      if (e_ready) begin
        bitv = in_valid ? in_data : 1'b0;
        if (!in_mode) begin
          e_line   = ~last2;
          pend     = bitv ^ last2;
          tag_line = !in_valid ? "R10" : (m_l ? "R9" : "R5");
          tag_mid  = bitv ? "R4" : "R3";
        end else begin
          e_line   = bitv;
          pend     = ~bitv;
          tag_line = !in_valid ? "R10" : "R6";
          tag_mid  = "R6";
        end
        last2   = pend;
        m_l     = in_mode;
        e_first = 1'b1;
        e_ready = 1'b0;
      end else begin
        e_line   = pend;
        e_first  = 1'b0;
        e_ready  = 1'b1;
        tag_line = (in_mode !== m_l) ? "R7" : tag_mid;
      end
      @(negedge clk);
      chk(tag_line, line_out, e_line);
      chk("R8", line_first, e_first);
      chk("R2", in_ready, e_ready);
      if (e_first && !m_l) chk("R5", line_out != prev_line, 1'b1);
      prev_line = line_out;
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule